// File: doc/BRIEF.md
# Timer-Update DAC Trigger Router

This block sits between a set of timers and three DAC trigger lines. Seven update-event strobes come in: one from the master timer and one from each of six timer units. Each strobe is one clock wide and synchronous to the block clock. Each source has its own 2-bit route code. The code either sends that source's updates to one of the three trigger lines or disconnects the source.

A trigger line is the logical OR of every source currently routed to it. The line is registered, so each qualifying update becomes a pulse one clock wide, one cycle after the strobe. Route codes are written through a small write port that carries a write enable, a source index and a code. Every code is cleared to "disconnected" at reset.

Top module: `tu_dac_trig_router`

## Requirements
- R1: After reset every route code is 00 and `trig_o` is all zeros, so update strobes raise no trigger until a code is written.
- R2: Route code 01 sends a source to `trig_o[0]`, code 10 sends it to `trig_o[1]`, and code 11 sends it to `trig_o[2]`.
- R3: A source whose route code is 00 never raises any bit of `trig_o`, whatever its strobe does.
- R4: A strobe on `upd_i[s]` in cycle k raises the routed `trig_o` bit in cycle k+1 only. With no strobe in cycle k, every `trig_o` bit is low in cycle k+1.
- R5: Each `trig_o` bit is the OR of the strobes of all sources routed to it. Several such strobes in the same cycle give one pulse one clock wide.
- R6: A write of a valid index in cycle k governs strobes from cycle k+1 onward. A strobe in cycle k itself still uses the old code.
- R7: A write whose index is 7 or more (no such source) changes no route code.
- R8: A write changes only the indexed source's code, and with `cfg_we` low no code changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Route-code write enable |
| cfg_idx | input | 3 | Source index: 0 is the master, 1 to 6 are the timer units |
| cfg_sel | input | 2 | Route code to write (00 none, 01/10/11 trigger 0/1/2) |
| upd_i | input | 7 | Update strobes; bit 0 is the master, bits 1 to 6 are the units |
| trig_o | output | 3 | Registered DAC trigger pulses |

## Verification
The assertions check, on every cycle, that no trigger appears without a strobe in the cycle before or while all codes are 00. They also check that a write changes only the indexed field, lands exactly the written code, and leaves everything untouched for an out-of-range index or an idle write port. They do not show which trigger line a given code selects, or how simultaneous strobes merge into one pulse. Those, along with the old-code/new-code boundary at the cycle of a write, come from the bench's scenarios compared cycle by cycle against its behavioural model.

// File: rtl/dac_trig_pkg.sv
package dac_trig_pkg;
    localparam int SEL_W    = 2;
    localparam int NUM_TRIG = 3;

    typedef logic [SEL_W-1:0] route_code_t;

    localparam route_code_t ROUTE_NONE = 2'b00;
endpackage

// File: rtl/trig_sel_regs.sv
module trig_sel_regs
    import dac_trig_pkg::*;
#(
    parameter int NUM_SRC = 7,
    parameter int IDX_W   = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [IDX_W-1:0]         idx,
    input  route_code_t              code,
    output logic [NUM_SRC*SEL_W-1:0] sel_flat
);
    typedef struct packed {
        logic [NUM_SRC*SEL_W-1:0] sel;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int s = 0; s < NUM_SRC; s++) begin
            if (we && (idx == IDX_W'(s))) begin
                st_d.sel[s*SEL_W +: SEL_W] = code;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sel_flat = st_q.sel;
endmodule

// File: rtl/trig_route_merge.sv
module trig_route_merge
    import dac_trig_pkg::*;
#(
    parameter int NUM_SRC = 7
) (
    input  logic [NUM_SRC*SEL_W-1:0] sel_flat,
    input  logic [NUM_SRC-1:0]       upd,
    output logic [NUM_TRIG-1:0]      hit
);
    for (genvar t = 0; t < NUM_TRIG; t++) begin : g_line
        logic [NUM_SRC-1:0] routed;
        for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
            assign routed[s] = upd[s] &&
                (sel_flat[s*SEL_W +: SEL_W] == route_code_t'(t + 1));
        end
        assign hit[t] = |routed;
    end
endmodule

// File: rtl/trig_pulse_out.sv
module trig_pulse_out
    import dac_trig_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_TRIG-1:0] hit,
    output logic [NUM_TRIG-1:0] pulse
);
    typedef struct packed {
        logic [NUM_TRIG-1:0] trig;
    } outs_t;

    outs_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.trig = hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pulse = st_q.trig;
endmodule

// File: rtl/tu_dac_trig_router.sv
module tu_dac_trig_router
    import dac_trig_pkg::*;
#(
    parameter  int NUM_SRC = 7,
    localparam int IDX_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [IDX_W-1:0]    cfg_idx,
    input  logic [SEL_W-1:0]    cfg_sel,
    input  logic [NUM_SRC-1:0]  upd_i,
    output logic [NUM_TRIG-1:0] trig_o
);
    logic [NUM_SRC*SEL_W-1:0] sel_flat;
    logic [NUM_TRIG-1:0]      hit;

    trig_sel_regs #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (cfg_we),
        .idx      (cfg_idx),
        .code     (cfg_sel),
        .sel_flat (sel_flat)
    );

    trig_route_merge #(.NUM_SRC(NUM_SRC)) u_route (
        .sel_flat (sel_flat),
        .upd      (upd_i),
        .hit      (hit)
    );

    trig_pulse_out u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .hit   (hit),
        .pulse (trig_o)
    );
endmodule

// File: rtl/tu_dac_trig_router_chk.sv
module tu_dac_trig_router_chk
    import dac_trig_pkg::*;
#(
    parameter int NUM_SRC = 7,
    parameter int IDX_W   = 3
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     cfg_we,
    input logic [IDX_W-1:0]         cfg_idx,
    input logic [SEL_W-1:0]         cfg_sel,
    input logic [NUM_SRC-1:0]       upd_i,
    input logic [NUM_TRIG-1:0]      trig_o,
    input logic [NUM_SRC*SEL_W-1:0] sel_flat
);
    function automatic logic [SEL_W-1:0] field_of(
        input logic [NUM_SRC*SEL_W-1:0] v, input logic [IDX_W-1:0] i);
        logic [SEL_W-1:0] r = '0;
        for (int s = 0; s < NUM_SRC; s++) begin
            if (i == IDX_W'(s)) r = v[s*SEL_W +: SEL_W];
        end
        return r;
    endfunction

    function automatic logic [NUM_SRC*SEL_W-1:0] mask_of(input logic [IDX_W-1:0] i);
        logic [NUM_SRC*SEL_W-1:0] m = '0;
        for (int s = 0; s < NUM_SRC; s++) begin
            if (i == IDX_W'(s)) m[s*SEL_W +: SEL_W] = '1;
        end
        return m;
    endfunction

    p_reset_quiet_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> (trig_o == '0 && sel_flat == '0));

    p_no_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(upd_i) == '0) |-> (trig_o == '0));

    p_all_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sel_flat) == '0) |-> (trig_o == '0));

    p_bad_index_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && (int'(cfg_idx) >= NUM_SRC)) |=> $stable(sel_flat));

    p_idle_port_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(sel_flat));

    p_write_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && (int'(cfg_idx) < NUM_SRC))
        |=> (field_of(sel_flat, $past(cfg_idx)) == $past(cfg_sel)));

    p_one_field_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (((sel_flat ^ $past(sel_flat)) & ~mask_of($past(cfg_idx))) == '0));
endmodule

bind tu_dac_trig_router tu_dac_trig_router_chk #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_idx  (cfg_idx),
    .cfg_sel  (cfg_sel),
    .upd_i    (upd_i),
    .trig_o   (trig_o),
    .sel_flat (sel_flat)
);

// File: tb/sim_tu_dac_trig_router.sv
`timescale 1ns/1ps
module sim_tu_dac_trig_router;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [2:0] cfg_idx = '0;
    logic [1:0] cfg_sel = '0;
    logic [6:0] upd_i = '0;
    logic [2:0] trig_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    int ref_sel [7];
    logic [2:0] exp_trig = '0;

    always #10 clk = ~clk;

    tu_dac_trig_router u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_sel(cfg_sel), .upd_i(upd_i), .trig_o(trig_o)
    );

    function automatic logic [2:0] model(input logic [6:0] u);
        logic [2:0] r = '0;
        for (int s = 0; s < 7; s++) begin
            if (u[s] && ref_sel[s] != 0) r[ref_sel[s]-1] = 1'b1;
        end
        return r;
    endfunction

    task automatic check(input string tag, input logic [2:0] want);
        checks++;
        if (trig_o !== want) begin
            errors++;
            $display("FAIL %s trig_o=%b expected %b at %0t", tag, trig_o, want, $time);
        end
    endtask

    // One clock: compare last cycle's prediction, then drive this cycle.
    task automatic step(input string tag, input logic we, input int idx,
                        input int code, input logic [6:0] u);
        @(negedge clk);
        check(tag, exp_trig);
        cfg_we  = we;
        cfg_idx = 3'(idx);
        cfg_sel = 2'(code);
        upd_i   = u;
        exp_trig = model(u);
        if (we && idx < 7) ref_sel[idx] = code;
    endtask

    task automatic idle(input string tag, input int n);
        for (int i = 0; i < n; i++) step(tag, 1'b0, 0, 0, 7'h00);
    endtask

    initial begin
        for (int s = 0; s < 7; s++) ref_sel[s] = 0;
        repeat (3) begin
            @(negedge clk);
            check("R1 in reset", 3'b000);
        end
        rst_n = 1'b1;
        // R1: all codes reset to 00, strobes do nothing
        step("R1", 1'b0, 0, 0, 7'h7f);
        step("R1", 1'b0, 0, 0, 7'h55);
        idle("R1", 2);
        // R2: code mapping 01->bit0, 10->bit1, 11->bit2
        step("R2 cfg", 1'b1, 0, 1, 7'h00);
        step("R2 cfg", 1'b1, 1, 2, 7'h00);
        step("R2 cfg", 1'b1, 2, 3, 7'h00);
        step("R2", 1'b0, 0, 0, 7'h01);
        step("R2", 1'b0, 0, 0, 7'h02);
        step("R2", 1'b0, 0, 0, 7'h04);
        step("R4", 1'b0, 0, 0, 7'h00);
        // R4: isolated strobe gives one pulse of one clock
        step("R4", 1'b0, 0, 0, 7'h00);
        step("R4", 1'b0, 0, 0, 7'h04);
        idle("R4", 3);
        // R3: sources left at 00 do nothing even with others firing
        step("R3", 1'b0, 0, 0, 7'h78);
        step("R3", 1'b0, 0, 0, 7'h79);
        idle("R3", 1);
        // R5: two sources on line 0, simultaneous and back to back
        step("R5 cfg", 1'b1, 3, 1, 7'h00);
        step("R5 cfg", 1'b1, 4, 1, 7'h00);
        step("R5", 1'b0, 0, 0, 7'h18);
        step("R5", 1'b0, 0, 0, 7'h00);
        step("R5", 1'b0, 0, 0, 7'h08);
        step("R5", 1'b0, 0, 0, 7'h10);
        step("R5", 1'b0, 0, 0, 7'h19);
        idle("R5", 2);
        // R6: write and strobe in the same cycle use the old code
        step("R6", 1'b1, 2, 1, 7'h04);
        step("R6", 1'b0, 0, 0, 7'h04);
        step("R6", 1'b1, 5, 2, 7'h20);
        step("R6", 1'b0, 0, 0, 7'h20);
        idle("R6", 2);
        // R7: index 7 names no source
        step("R7", 1'b1, 7, 3, 7'h00);
        step("R7", 1'b0, 0, 0, 7'h7f);
        step("R7", 1'b0, 0, 0, 7'h40);
        idle("R7", 1);
        // R8: rewriting one source leaves the others
        step("R8", 1'b1, 0, 0, 7'h00);
        step("R8", 1'b0, 0, 0, 7'h01);
        step("R8", 1'b0, 0, 0, 7'h02);
        step("R8", 1'b0, 0, 0, 7'h3e);
        idle("R8", 2);
        // Mixed traffic (R2 R5 R6 R7 R8)
        for (int i = 0; i < 400; i++) begin
            step("R5 mixed", 1'(($urandom % 4) == 0), int'($urandom % 8),
                 int'($urandom % 4), 7'($urandom));
        end
        idle("R4 tail", 2);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog trig_o=%b expected completion", trig_o);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule